// File: doc/BRIEF.md
# Width-Preserving Input Glitch Filter

This block cleans up one logic command input of a half-bridge gate driver, such as the high-side or low-side enable. The raw pin is first brought into the clock domain through a chain of flip-flops. A qualifier stage then accepts a new level only after the synchronised signal has held that level for a programmable number of clock cycles. Both rising and falling transitions wait for the same qualification time, so the output reproduces any accepted pulse with its original width. Short positive spikes on a low line and short negative dips on a high line are both discarded and leave no trace on the output.

The qualification time comes in on a port as a cycle count. Software or a strap fixes it to match the wanted rejection window, for example around 350 ns, kept inside the 200 to 510 ns band. At 50 MHz that is roughly 10 to 25 cycles. Each command line of the driver gets its own instance.

Top module: `dglt_filter`

## Requirements
- R1: While rst_ni is low, filt_o is 0. Once reset is released, the output stays 0 until the input has been high for a full qualification time.
- R2: The raw input passes through SYNC_STAGES (default 2) flip-flops. A level change on din_i that is held long enough shows up on filt_o exactly SYNC_STAGES + L clock edges after the first edge that samples it. L is the effective limit, equal to filt_cycles_i, or 1 when filt_cycles_i is 0.
- R3: A high pulse on a low input that lasts fewer than L cycles leaves filt_o at 0 throughout.
- R4: A low dip on a high input that lasts fewer than L cycles leaves filt_o at 1 throughout.
- R5: A pulse of either polarity that lasts W >= L cycles appears on filt_o with exactly W cycles of width, because both of its edges are delayed equally. A pulse of exactly L cycles passes.
- R6: If the synchronised input returns to the current output level before the count reaches L, the count restarts from zero. Two sub-limit pulses split by a one-cycle gap therefore do not add up to a pass.
- R7: filt_cycles_i = 0 behaves the same as 1: a single-cycle pulse passes with a width of one cycle.
- R8: The output changes only toward the level of the synchronised input, and never while that input equals the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Filter clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| din_i | input | 1 | Raw, asynchronous command input |
| filt_cycles_i | input | CNT_W | Qualification time in clock cycles (0 acts as 1) |
| filt_o | output | 1 | Filtered, width-preserved command |

## Verification
Two events can fall on the same clock edge: the qualification count reaching its limit, and the synchronised input reverting to the old level. The bench provokes this with pulses of exactly L and L-1 cycles. The first must pass at full width and the second must vanish. A restart pattern of two L-2 pulses split by a one-cycle gap checks that a reversion in the middle of a count discards the count, rather than pausing it.

// File: rtl/dglt_pkg.sv
package dglt_pkg;
  localparam int unsigned SYNC_STAGES_DEF = 2;
  localparam int unsigned CNT_W_DEF       = 6;

  typedef enum logic {
    LVL_LOW  = 1'b0,
    LVL_HIGH = 1'b1
  } lvl_e;
endpackage

// File: rtl/dglt_sync.sv
module dglt_sync #(
  parameter int unsigned STAGES = dglt_pkg::SYNC_STAGES_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[0] <= dglt_pkg::LVL_LOW;
          else         chain_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[g] <= dglt_pkg::LVL_LOW;
          else         chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/dglt_qual.sv
module dglt_qual #(
  parameter int unsigned CNT_W = dglt_pkg::CNT_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lvl_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             lvl_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam int unsigned CW1 = CNT_W + 1;

  logic [CNT_W-1:0] lim;
  logic [CNT_W-1:0] cnt_q;
  logic             out_q;
  logic [CW1-1:0]   streak;
  logic             commit;

  // zero limit acts as one cycle
  assign lim    = (limit_i == '0) ? CNT_W'(1) : limit_i;
  assign streak = {1'b0, cnt_q} + CW1'(1);
  assign commit = (lvl_i != out_q) && (streak >= {1'b0, lim});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= dglt_pkg::LVL_LOW;
      cnt_q <= '0;
    end else if (lvl_i == out_q) begin
      cnt_q <= '0;
    end else if (commit) begin
      out_q <= lvl_i;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign lvl_o = out_q;
  assign cnt_o = cnt_q;
endmodule

// File: rtl/dglt_filter.sv
module dglt_filter #(
  parameter int unsigned SYNC_STAGES = dglt_pkg::SYNC_STAGES_DEF,
  parameter int unsigned CNT_W       = dglt_pkg::CNT_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             din_i,
  input  logic [CNT_W-1:0] filt_cycles_i,
  output logic             filt_o
);
  logic             sync_lvl;
  logic [CNT_W-1:0] cnt_lvl;

  dglt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (din_i),
    .q_o   (sync_lvl)
  );

  dglt_qual #(.CNT_W(CNT_W)) u_qual (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (sync_lvl),
    .limit_i(filt_cycles_i),
    .lvl_o  (filt_o),
    .cnt_o  (cnt_lvl)
  );
endmodule

// File: rtl/dglt_filter_chk.sv
module dglt_filter_chk #(
  parameter int unsigned CNT_W = dglt_pkg::CNT_W_DEF
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sync_lvl,
  input logic [CNT_W-1:0] filt_cycles_i,
  input logic             filt_o,
  input logic [CNT_W-1:0] cnt_lvl
);
  localparam int unsigned RW = CNT_W + 1;

  logic [RW-1:0] run_q;
  logic [RW-1:0] lim_w;

  assign lim_w = (filt_cycles_i == '0) ? RW'(1) : {1'b0, filt_cycles_i};

  // consecutive mismatch edges seen independently of the qualifier
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                run_q <= '0;
    else if (sync_lvl == filt_o) run_q <= '0;
    else if (run_q != '1)       run_q <= run_q + RW'(1);
  end

  // R1
  reset_low_chk: assert property (@(posedge clk_i) !rst_ni |-> !filt_o);

  // R8
  match_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_lvl == filt_o) |=> $stable(filt_o));

  // R6
  short_streak_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sync_lvl != filt_o) && ((run_q + RW'(1)) < lim_w)) |=> $stable(filt_o));

  // R6
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {1'b0, cnt_lvl} < lim_w);
endmodule

bind dglt_filter dglt_filter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sync_lvl     (sync_lvl),
  .filt_cycles_i(filt_cycles_i),
  .filt_o       (filt_o),
  .cnt_lvl      (cnt_lvl)
);

// File: tb/dglt_filter_tb.sv
module dglt_filter_tb;
  localparam int unsigned CNT_W = 6;
  localparam int unsigned NV    = 11;

  // {limit, base level, pulse width, expected output width}
  typedef struct packed {
    logic [7:0] lim;
    logic       base;
    logic [7:0] width;
    logic [7:0] exp_w;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{8'd5,  1'b0, 8'd3,  8'd0},   // R3
    '{8'd5,  1'b0, 8'd4,  8'd0},   // R3 L-1
    '{8'd5,  1'b0, 8'd5,  8'd5},   // R5 exactly L
    '{8'd5,  1'b0, 8'd20, 8'd20},  // R5
    '{8'd5,  1'b1, 8'd4,  8'd0},   // R4
    '{8'd5,  1'b1, 8'd5,  8'd5},   // R5 low pulse at L
    '{8'd5,  1'b1, 8'd12, 8'd12},  // R5
    '{8'd0,  1'b0, 8'd1,  8'd1},   // R7
    '{8'd1,  1'b0, 8'd1,  8'd1},   // R7 reference
    '{8'd17, 1'b0, 8'd16, 8'd0},   // R3
    '{8'd17, 1'b0, 8'd40, 8'd40}   // R5
  };

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             din_i = 1'b0;
  logic [CNT_W-1:0] filt_cycles_i = CNT_W'(5);
  logic             filt_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk_i = ~clk_i;

  dglt_filter #(.SYNC_STAGES(2), .CNT_W(CNT_W)) u_dut (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .din_i        (din_i),
    .filt_cycles_i(filt_cycles_i),
    .filt_o       (filt_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic settle(input logic lvl, input int cyc);
    din_i = lvl;
    for (int i = 0; i < cyc; i++) @(negedge clk_i);
  endtask

  // counts samples where output differs from base while a pulse is applied
  task automatic pulse(input logic base, input int w, input int lim, output int seen);
    seen = 0;
    for (int i = 0; i < w + lim + 12; i++) begin
      din_i = (i < w) ? ~base : base;
      @(negedge clk_i);
      if (filt_o != base) seen++;
    end
  endtask

  // number of sampled cycles until output reaches lvl
  task automatic latency(input logic lvl, output int n);
    n = 0;
    din_i = lvl;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk_i);
      n++;
      if (filt_o == lvl) break;
    end
  endtask

  initial begin
    int seen;
    int lat;
    @(negedge clk_i);
    chk(filt_o == 1'b0, "R1 output low in reset", filt_o, 0);
    din_i = 1'b1;
    for (int i = 0; i < 5; i++) @(negedge clk_i);
    chk(filt_o == 1'b0, "R1 high input ignored in reset", filt_o, 0);
    din_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    settle(1'b0, 5);
    chk(filt_o == 1'b0, "R1 output low after release", filt_o, 0);

    for (int v = 0; v < NV; v++) begin
      filt_cycles_i = CNT_W'(VECS[v].lim);
      settle(VECS[v].base, 45);
      pulse(VECS[v].base, int'(VECS[v].width), int'(VECS[v].lim), seen);
      chk(seen == int'(VECS[v].exp_w),
          $sformatf("R3/R4/R5/R7 vector %0d width", v), seen, int'(VECS[v].exp_w));
    end

    // R2 edge latency equal for both directions: SYNC_STAGES + L
    filt_cycles_i = CNT_W'(6);
    settle(1'b0, 30);
    latency(1'b1, lat);
    chk(lat == 8, "R2 rise latency", lat, 8);
    settle(1'b1, 20);
    latency(1'b0, lat);
    chk(lat == 8, "R2 fall latency", lat, 8);

    // R6 restart: two 6-cycle pulses with a 1-cycle gap, limit 8
    filt_cycles_i = CNT_W'(8);
    settle(1'b0, 30);
    seen = 0;
    for (int i = 0; i < 40; i++) begin
      din_i = ((i < 6) || (i >= 7 && i < 13)) ? 1'b1 : 1'b0;
      @(negedge clk_i);
      if (filt_o) seen++;
    end
    chk(seen == 0, "R6 reversion restarts count", seen, 0);

    // R6 same pattern with dip on a high line
    settle(1'b1, 30);
    seen = 0;
    for (int i = 0; i < 40; i++) begin
      din_i = ((i < 6) || (i >= 7 && i < 13)) ? 1'b0 : 1'b1;
      @(negedge clk_i);
      if (!filt_o) seen++;
    end
    chk(seen == 0, "R6 reversion restarts count (low)", seen, 0);

    // R1 reset while output high
    chk(filt_o == 1'b1, "R1 precondition output high", filt_o, 1);
    #3 rst_ni = 1'b0;
    #2;
    chk(filt_o == 1'b0, "R1 asynchronous clear", filt_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    din_i = 1'b1;
    for (int i = 0; i < 9; i++) @(negedge clk_i);
    chk(filt_o == 1'b0, "R1 requalify after reset", filt_o, 0);
    @(negedge clk_i);
    chk(filt_o == 1'b1, "R1/R2 requalified at limit", filt_o, 1);

    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 100000; i++) begin
      @(posedge clk_i);
      if (done) break;
    end
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule